// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block drives the clock-enable line of every DRAM rank behind a memory controller. It takes the processor power state, the graphics and display status and the memory request status, and from these it selects one of three memory conditions. In the first, each rank is powered down dynamically when it goes idle. In the second, the whole memory is placed in self-refresh. In the third, the memory is switched off and its contents are lost.

During dynamic operation each rank has an idle counter. When the counter runs out, the rank's clock enable is dropped. Depending on a configuration bit, the rank either drops at once with its pages still open, or first asks for a precharge-all and waits for it to complete. An access to a sleeping rank raises its clock enable and holds the grant back for a programmable exit delay. A periodic refresh is bracketed: every populated rank is woken before the refresh is granted, and all of them are dropped again when it completes. Ranks that are not populated are kept off at all times.

Top module: `rank_pwr_ctl`

## Requirements
- R1: While reset is applied and after its release, every `cke` bit is low and `rankGrant`, `srActive`, `refreshGrant` and `memOff` are all zero.
- R2: Suppose an access to a populated, powered-down rank is sampled at clock edge E. Then `cke` for that rank is high from E onwards. With the access still held, the grant appears after edge E+`exitDelay`+1.
- R3: A rank that is up reloads its idle counter to `idleLimit` on every sampled access. When `dynPdEn`=1, no refresh is in progress and `prechargeMode`=0, its `cke` drops at the edge `idleLimit`+1 edges after the last sampled access. When `dynPdEn`=0, the rank stays up.
- R4: When `prechargeMode`=1, the rank raises `prechargeReq` at that same edge instead, and its `cke` stays high. At the edge that samples the rank's `prechargeDone` bit, `cke` drops and `prechargeReq` clears.
- R5: A sampled `refreshReq`, arriving while no self-refresh or power-off is active or wanted, wakes every populated rank (the exit delay applies). `refreshGrant` rises one edge after all populated ranks are up. While the refresh is in progress, no access is granted and no rank idles down.
- R6: A `refreshDone` sampled during the grant drops `refreshGrant` at that edge. If `dynPdEn`=1, all ranks drop `cke` at the following edge.
- R7: `cpuState` codes 0 (C0), 1 (C1), 2 (C1E) and 7 never enter self-refresh. Changing to one of them while in self-refresh ends it.
- R8: In codes 3 (C3) and 4 (C6) with `gfxExternal`=0, self-refresh is wanted exactly when `gfxIdle`=1, `dispPending`=0 and `singleDisplay`=1.
- R9: In codes 3 and 4 with `gfxExternal`=1, self-refresh is wanted exactly when `memReqPending`=0.
- R10: Code 5 (S3) always wants self-refresh. Code 6 (S4) sets `memOff` one edge later and ends any self-refresh. While `memOff` is set, all `cke` bits are low and no access or refresh is granted.
- R11: `srActive` follows the wanted condition one edge later. Entry is not allowed while a refresh is in progress. `srEnter` and `srExit` are one-cycle pulses in the cycle where `srActive` changes. While `srActive` is set, all `cke` bits are low and no access or refresh is granted. After exit, ranks stay down until they are accessed.
- R12: A rank whose `rankPopulated` bit is 0 keeps `cke` low and is never granted. Refresh does not wait for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuState | input | 3 | Processor power state code |
| gfxExternal | input | 1 | 1: discrete graphics, 0: integrated graphics |
| gfxIdle | input | 1 | Integrated graphics engine is idle |
| dispPending | input | 1 | Display requests are outstanding |
| singleDisplay | input | 1 | Exactly one display is active |
| memReqPending | input | 1 | Memory requests are outstanding |
| dynPdEn | input | 1 | Enables dynamic per-rank power-down |
| prechargeMode | input | 1 | 1: precharge power-down, 0: active power-down |
| idleLimit | input | IDLE_W | Idle cycles before power-down |
| exitDelay | input | EXIT_W | Extra wake cycles before a grant |
| rankPopulated | input | NUM_RANKS | Population mask |
| rankAccess | input | NUM_RANKS | Per-rank access request |
| rankGrant | output | NUM_RANKS | Per-rank access grant |
| cke | output | NUM_RANKS | Per-rank clock enable |
| prechargeReq | output | NUM_RANKS | Per-rank precharge-all request |
| prechargeDone | input | NUM_RANKS | Per-rank precharge-all completion |
| refreshReq | input | 1 | Refresh is due |
| refreshDone | input | 1 | Refresh has finished |
| refreshGrant | output | 1 | Refresh may proceed |
| srActive | output | 1 | Memory is in self-refresh |
| srEnter | output | 1 | Self-refresh entry pulse |
| srExit | output | 1 | Self-refresh exit pulse |
| memOff | output | 1 | Memory is powered off |

## Verification
The bench checks the exact edge on which a grant follows a wake-up, and the edge on which a rank idles out. A design that grants early, or that fails to reload its counter, fails on the cycle count. It holds `prechargeDone` back for several cycles, which exposes a design that drops `cke` before the precharge completes. During a refresh it includes an unpopulated rank and an access. A design that waits for the absent rank would never grant the refresh, and one that lets ranks idle or grants the access would show a wrong `cke` or grant. It also steps through the graphics and display conditions one at a time in the deep states, applies S3 and S4, and issues refreshes and accesses during self-refresh. A wrong policy then shows up as a wrong `srActive`, a missing pulse, or a clock enable raised while the memory should be off.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

  // Processor power state codes seen on cpuState
  typedef enum logic [2:0] {
    CPU_C0   = 3'd0,
    CPU_C1   = 3'd1,
    CPU_C1E  = 3'd2,
    CPU_C3   = 3'd3,
    CPU_C6   = 3'd4,
    CPU_S3   = 3'd5,
    CPU_S4   = 3'd6,
    CPU_RSVD = 3'd7
  } cpu_state_e;

  // Per-rank power condition
  typedef enum logic [1:0] {
    RK_UP    = 2'd0,
    RK_PRECH = 2'd1,
    RK_DOWN  = 2'd2,
    RK_WAKE  = 2'd3
  } rank_state_e;

  // Refresh bracketing sequence
  typedef enum logic [1:0] {
    REF_IDLE  = 2'd0,
    REF_WAKE  = 2'd1,
    REF_GRANT = 2'd2,
    REF_DROP  = 2'd3
  } ref_state_e;

  // Strobes from the policy control to the rank datapath
  typedef struct packed {
    logic forceDown;  // self-refresh or power-off: every rank off
    logic wakeAll;    // refresh bracket: bring every populated rank up
    logic dropAll;    // refresh finished: put every rank down
    logic holdOff;    // refresh in progress: no grants, no idle power-down
  } lane_ctl_t;

endpackage

// File: rtl/rank_pwr_policy.sv
module rank_pwr_policy
  import rank_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cpuState,
  input  logic       gfxExternal,
  input  logic       gfxIdle,
  input  logic       dispPending,
  input  logic       singleDisplay,
  input  logic       memReqPending,
  input  logic       dynPdEn,
  input  logic       refreshReq,
  input  logic       refreshDone,
  input  logic       allUp,
  output lane_ctl_t  laneCtl,
  output logic       refreshGrant,
  output logic       srActive,
  output logic       srEnter,
  output logic       srExit,
  output logic       memOff
);

  cpu_state_e cpuNow;
  ref_state_e refState;
  logic       deepIdle;
  logic       gfxQuiet;
  logic       srWanted;
  logic       refStartOk;
  logic       isS4;

  assign cpuNow   = cpu_state_e'(cpuState);
  assign deepIdle = (cpuNow == CPU_C3) || (cpuNow == CPU_C6);
  assign isS4     = (cpuNow == CPU_S4);
  assign gfxQuiet = gfxIdle && !dispPending && singleDisplay;

  // Target memory condition from processor state and graphics/request status
  always_comb begin
    srWanted = 1'b0;
    if (cpuNow == CPU_S3) begin
      srWanted = 1'b1;
    end else if (deepIdle) begin
      srWanted = gfxExternal ? !memReqPending : gfxQuiet;
    end
  end

  assign refStartOk = refreshReq && !srWanted && !srActive && !memOff && !isS4;

  // Self-refresh and power-off tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srActive <= 1'b0;
      srEnter  <= 1'b0;
      srExit   <= 1'b0;
      memOff   <= 1'b0;
    end else begin
      srEnter <= 1'b0;
      srExit  <= 1'b0;
      memOff  <= isS4;
      if (!srActive && srWanted && (refState == REF_IDLE)) begin
        srActive <= 1'b1;
        srEnter  <= 1'b1;
      end else if (srActive && !srWanted) begin
        srActive <= 1'b0;
        srExit   <= 1'b1;
      end
    end
  end

  // Refresh bracket: wake all, grant, drop all
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refState <= REF_IDLE;
    end else if (isS4) begin
      refState <= REF_IDLE;
    end else begin
      case (refState)
        REF_IDLE:  if (refStartOk)  refState <= REF_WAKE;
        REF_WAKE:  if (allUp)       refState <= REF_GRANT;
        REF_GRANT: if (refreshDone) refState <= REF_DROP;
        REF_DROP:                   refState <= REF_IDLE;
        default:                    refState <= REF_IDLE;
      endcase
    end
  end

  always_comb begin
    laneCtl.forceDown = srActive || memOff;
    laneCtl.wakeAll   = (refState == REF_WAKE);
    laneCtl.dropAll   = (refState == REF_DROP) && dynPdEn;
    laneCtl.holdOff   = (refState != REF_IDLE);
  end

  assign refreshGrant = (refState == REF_GRANT);

endmodule

// File: rtl/rank_pwr_lanes.sv
module rank_pwr_lanes
  import rank_pwr_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int IDLE_W    = 8,
  parameter int EXIT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lane_ctl_t            laneCtl,
  input  logic                 dynPdEn,
  input  logic                 prechargeMode,
  input  logic [IDLE_W-1:0]    idleLimit,
  input  logic [EXIT_W-1:0]    exitDelay,
  input  logic [NUM_RANKS-1:0] rankPopulated,
  input  logic [NUM_RANKS-1:0] rankAccess,
  input  logic [NUM_RANKS-1:0] prechargeDone,
  output logic [NUM_RANKS-1:0] cke,
  output logic [NUM_RANKS-1:0] rankGrant,
  output logic [NUM_RANKS-1:0] prechargeReq,
  output logic                 allUp
);

  localparam logic [IDLE_W-1:0] IDLE_ONE = IDLE_W'(1);
  localparam logic [EXIT_W-1:0] EXIT_ONE = EXIT_W'(1);

  logic [NUM_RANKS-1:0] rankReady;

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
    rank_state_e       rankSt;
    logic [IDLE_W-1:0] idleCnt;
    logic [EXIT_W-1:0] exitCnt;
    logic              live;

    assign live = rankPopulated[g] && !laneCtl.forceDown;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rankSt  <= RK_DOWN;
        idleCnt <= '0;
        exitCnt <= '0;
      end else if (!live) begin
        rankSt <= RK_DOWN;
      end else begin
        case (rankSt)
          RK_UP: begin
            if (laneCtl.dropAll) begin
              rankSt <= RK_DOWN;
            end else if (rankAccess[g]) begin
              idleCnt <= idleLimit;
            end else if (idleCnt != '0) begin
              idleCnt <= idleCnt - IDLE_ONE;
            end else if (dynPdEn && !laneCtl.holdOff) begin
              rankSt <= prechargeMode ? RK_PRECH : RK_DOWN;
            end
          end
          RK_PRECH: begin
            if (laneCtl.wakeAll) begin
              rankSt  <= RK_UP;
              idleCnt <= idleLimit;
            end else if (prechargeDone[g]) begin
              rankSt <= RK_DOWN;
            end
          end
          RK_DOWN: begin
            if (rankAccess[g] || laneCtl.wakeAll) begin
              rankSt  <= RK_WAKE;
              exitCnt <= exitDelay;
            end
          end
          RK_WAKE: begin
            if (exitCnt == '0) begin
              rankSt  <= RK_UP;
              idleCnt <= idleLimit;
            end else begin
              exitCnt <= exitCnt - EXIT_ONE;
            end
          end
          default: rankSt <= RK_DOWN;
        endcase
      end
    end

    assign cke[g]          = live && (rankSt != RK_DOWN);
    assign prechargeReq[g] = live && (rankSt == RK_PRECH);
    assign rankGrant[g]    = live && !laneCtl.holdOff && (rankSt == RK_UP) && rankAccess[g];
    assign rankReady[g]    = !rankPopulated[g] || (rankSt == RK_UP);
  end

  assign allUp = &rankReady;

endmodule

// File: rtl/rank_pwr_ctl.sv
module rank_pwr_ctl
  import rank_pwr_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int IDLE_W    = 8,
  parameter int EXIT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cpuState,
  input  logic                 gfxExternal,
  input  logic                 gfxIdle,
  input  logic                 dispPending,
  input  logic                 singleDisplay,
  input  logic                 memReqPending,
  input  logic                 dynPdEn,
  input  logic                 prechargeMode,
  input  logic [IDLE_W-1:0]    idleLimit,
  input  logic [EXIT_W-1:0]    exitDelay,
  input  logic [NUM_RANKS-1:0] rankPopulated,
  input  logic [NUM_RANKS-1:0] rankAccess,
  output logic [NUM_RANKS-1:0] rankGrant,
  output logic [NUM_RANKS-1:0] cke,
  output logic [NUM_RANKS-1:0] prechargeReq,
  input  logic [NUM_RANKS-1:0] prechargeDone,
  input  logic                 refreshReq,
  input  logic                 refreshDone,
  output logic                 refreshGrant,
  output logic                 srActive,
  output logic                 srEnter,
  output logic                 srExit,
  output logic                 memOff
);

  lane_ctl_t laneCtl;
  logic      allUp;

  rank_pwr_policy i_policy (
    .clk          (clk),
    .rstN         (rstN),
    .cpuState     (cpuState),
    .gfxExternal  (gfxExternal),
    .gfxIdle      (gfxIdle),
    .dispPending  (dispPending),
    .singleDisplay(singleDisplay),
    .memReqPending(memReqPending),
    .dynPdEn      (dynPdEn),
    .refreshReq   (refreshReq),
    .refreshDone  (refreshDone),
    .allUp        (allUp),
    .laneCtl      (laneCtl),
    .refreshGrant (refreshGrant),
    .srActive     (srActive),
    .srEnter      (srEnter),
    .srExit       (srExit),
    .memOff       (memOff)
  );

  rank_pwr_lanes #(
    .NUM_RANKS(NUM_RANKS),
    .IDLE_W   (IDLE_W),
    .EXIT_W   (EXIT_W)
  ) i_lanes (
    .clk          (clk),
    .rstN         (rstN),
    .laneCtl      (laneCtl),
    .dynPdEn      (dynPdEn),
    .prechargeMode(prechargeMode),
    .idleLimit    (idleLimit),
    .exitDelay    (exitDelay),
    .rankPopulated(rankPopulated),
    .rankAccess   (rankAccess),
    .prechargeDone(prechargeDone),
    .cke          (cke),
    .rankGrant    (rankGrant),
    .prechargeReq (prechargeReq),
    .allUp        (allUp)
  );

endmodule

// File: rtl/rank_pwr_ctl_chk.sv
module rank_pwr_ctl_chk #(
  parameter int NUM_RANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           cpuState,
  input logic [NUM_RANKS-1:0] cke,
  input logic [NUM_RANKS-1:0] rankPopulated,
  input logic [NUM_RANKS-1:0] rankGrant,
  input logic [NUM_RANKS-1:0] prechargeReq,
  input logic                 refreshGrant,
  input logic                 srActive,
  input logic                 srEnter,
  input logic                 srExit,
  input logic                 memOff
);

  // R5
  refresh_all_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshGrant |-> (cke == rankPopulated));

  // R5
  refresh_not_sr_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshGrant |-> !srActive);

  // R11
  sr_cke_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    srActive |-> (cke == '0));

  // R11
  sr_enter_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    srEnter |=> !srEnter);

  // R11
  sr_exit_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    srExit |-> (!srActive && $past(srActive)));

  // R7
  deep_only_sr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srActive) |-> ($past(cpuState) inside {3'd3, 3'd4, 3'd5}));

  // R2
  grant_needs_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rankGrant & ~cke) == '0);

  // R4
  precharge_needs_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prechargeReq & ~cke) == '0);

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    memOff |-> ((cke == '0) && !refreshGrant && !srActive));

endmodule

bind rank_pwr_ctl rank_pwr_ctl_chk #(.NUM_RANKS(NUM_RANKS)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuState     (cpuState),
  .cke          (cke),
  .rankPopulated(rankPopulated),
  .rankGrant    (rankGrant),
  .prechargeReq (prechargeReq),
  .refreshGrant (refreshGrant),
  .srActive     (srActive),
  .srEnter      (srEnter),
  .srExit       (srExit),
  .memOff       (memOff)
);

// File: tb/test_rank_pwr_ctl.sv
`timescale 1ns/1ps
module test_rank_pwr_ctl;

  localparam int NR = 4;
  localparam int S_CKE = 0, S_GNT = 1, S_PRE = 2, S_SRA = 3;
  localparam int S_SEN = 4, S_SEX = 5, S_REF = 6, S_OFF = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    cpuState = 3'd0;
  logic          gfxExternal = 1'b0, gfxIdle = 1'b0, dispPending = 1'b0;
  logic          singleDisplay = 1'b0, memReqPending = 1'b0;
  logic          dynPdEn = 1'b1, prechargeMode = 1'b0;
  logic [7:0]    idleLimit = 8'd3;
  logic [2:0]    exitDelay = 3'd2;
  logic [NR-1:0] rankPopulated = 4'b0111, rankAccess = '0, prechargeDone = '0;
  logic [NR-1:0] rankGrant, cke, prechargeReq;
  logic          refreshReq = 1'b0, refreshDone = 1'b0;
  logic          refreshGrant, srActive, srEnter, srExit, memOff;

  always #2.5 clk = ~clk;

  rank_pwr_ctl #(.NUM_RANKS(NR), .IDLE_W(8), .EXIT_W(3)) i_rank_pwr_ctl (
    .clk(clk), .rstN(rstN), .cpuState(cpuState), .gfxExternal(gfxExternal),
    .gfxIdle(gfxIdle), .dispPending(dispPending), .singleDisplay(singleDisplay),
    .memReqPending(memReqPending), .dynPdEn(dynPdEn), .prechargeMode(prechargeMode),
    .idleLimit(idleLimit), .exitDelay(exitDelay), .rankPopulated(rankPopulated),
    .rankAccess(rankAccess), .rankGrant(rankGrant), .cke(cke),
    .prechargeReq(prechargeReq), .prechargeDone(prechargeDone),
    .refreshReq(refreshReq), .refreshDone(refreshDone), .refreshGrant(refreshGrant),
    .srActive(srActive), .srEnter(srEnter), .srExit(srExit), .memOff(memOff)
  );

  typedef struct {
    int          due;
    int          sig;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  item_t keepQ[$];
  int    cyc = 0;
  int    vectors = 0;
  int    miss = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc++;

  // Driver side: queue an expected value for a later cycle
  task automatic expectAt(int d, int sig, logic [31:0] v, string tag);
    item_t it;
    it.due = cyc + d;
    it.sig = sig;
    it.exp = v;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] sampleSig(int sig);
    case (sig)
      S_CKE:   return 32'(cke);
      S_GNT:   return 32'(rankGrant);
      S_PRE:   return 32'(prechargeReq);
      S_SRA:   return 32'(srActive);
      S_SEN:   return 32'(srEnter);
      S_SEX:   return 32'(srExit);
      S_REF:   return 32'(refreshGrant);
      default: return 32'(memOff);
    endcase
  endfunction

  // Monitor side: compare the items due in this cycle, away from the edge
  always @(negedge clk) begin
    logic [31:0] act;
    keepQ = {};
    foreach (sbq[i]) begin
      if (sbq[i].due == cyc) begin
        vectors++;
        act = sampleSig(sbq[i].sig);
        if (act !== sbq[i].exp) begin
          miss++;
          $display("FAIL %s cycle %0d signal %0d actual %0h expected %0h",
                   sbq[i].tag, cyc, sbq[i].sig, act, sbq[i].exp);
        end
      end else begin
        keepQ.push_back(sbq[i]);
      end
    end
    sbq = keepQ;
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    expectAt(0, S_CKE, 0, "R1");
    expectAt(0, S_GNT, 0, "R1");
    expectAt(0, S_SRA, 0, "R1");
    expectAt(0, S_REF, 0, "R1");
    expectAt(0, S_OFF, 0, "R1");
    tick(2);

    // R2 wake and exit delay, R3 idle timeout in active mode
    rankAccess = 4'b0001;
    expectAt(1, S_CKE, 1, "R2");
    expectAt(1, S_GNT, 0, "R2");
    expectAt(3, S_GNT, 0, "R2");
    expectAt(4, S_GNT, 1, "R2");
    tick(5);
    rankAccess = '0;
    expectAt(3, S_CKE, 1, "R3");
    expectAt(4, S_CKE, 0, "R3");
    tick(6);

    // R4 precharge power-down waits for completion
    prechargeMode = 1'b1;
    rankAccess = 4'b0010;
    expectAt(4, S_GNT, 2, "R2");
    tick(5);
    rankAccess = '0;
    expectAt(4, S_PRE, 2, "R4");
    expectAt(4, S_CKE, 2, "R4");
    expectAt(7, S_PRE, 2, "R4");
    expectAt(7, S_CKE, 2, "R4");
    tick(7);
    prechargeDone = 4'b0010;
    expectAt(1, S_CKE, 0, "R4");
    expectAt(1, S_PRE, 0, "R4");
    tick(1);
    prechargeDone = '0;
    prechargeMode = 1'b0;
    tick(2);

    // R5 refresh wakes populated ranks only, R12 absent rank not awaited
    refreshReq = 1'b1;
    expectAt(2, S_CKE, 7, "R5");
    expectAt(5, S_REF, 0, "R5");
    expectAt(6, S_REF, 1, "R5");
    expectAt(6, S_CKE, 7, "R12");
    tick(1);
    refreshReq = 1'b0;
    tick(7);
    rankAccess = 4'b0001;
    expectAt(0, S_GNT, 0, "R5");
    tick(1);
    rankAccess = '0;
    expectAt(2, S_CKE, 7, "R5");
    tick(3);
    // R6 refresh end drops everything
    refreshDone = 1'b1;
    expectAt(1, S_REF, 0, "R6");
    expectAt(1, S_CKE, 7, "R6");
    expectAt(2, S_CKE, 0, "R6");
    tick(1);
    refreshDone = 1'b0;
    tick(2);

    // R12 unpopulated rank ignores access
    rankAccess = 4'b1000;
    expectAt(1, S_CKE, 0, "R12");
    expectAt(4, S_GNT, 0, "R12");
    tick(5);
    rankAccess = '0;
    tick(1);

    // R3 dynamic power-down disabled keeps rank up
    dynPdEn = 1'b0;
    rankAccess = 4'b0001;
    tick(5);
    rankAccess = '0;
    expectAt(8, S_CKE, 1, "R3");
    tick(9);

    // R9 external graphics in C3, R11 pulses and blocking
    gfxExternal = 1'b1;
    memReqPending = 1'b1;
    cpuState = 3'd3;
    expectAt(2, S_SRA, 0, "R9");
    expectAt(2, S_CKE, 1, "R9");
    tick(2);
    memReqPending = 1'b0;
    expectAt(1, S_SRA, 1, "R9");
    expectAt(1, S_SEN, 1, "R11");
    expectAt(1, S_CKE, 0, "R11");
    expectAt(2, S_SEN, 0, "R11");
    tick(3);
    refreshReq = 1'b1;
    rankAccess = 4'b0001;
    expectAt(2, S_REF, 0, "R11");
    expectAt(2, S_GNT, 0, "R11");
    expectAt(2, S_CKE, 0, "R11");
    tick(3);
    refreshReq = 1'b0;
    rankAccess = '0;
    memReqPending = 1'b1;
    expectAt(1, S_SRA, 0, "R9");
    expectAt(1, S_SEX, 1, "R11");
    expectAt(2, S_SEX, 0, "R11");
    expectAt(2, S_CKE, 0, "R11");
    tick(3);
    dynPdEn = 1'b1;

    // R7 shallow state never self-refreshes
    cpuState = 3'd2;
    memReqPending = 1'b0;
    expectAt(3, S_SRA, 0, "R7");
    tick(4);

    // R8 integrated graphics in C6
    gfxExternal = 1'b0;
    gfxIdle = 1'b1;
    dispPending = 1'b0;
    singleDisplay = 1'b0;
    cpuState = 3'd4;
    expectAt(2, S_SRA, 0, "R8");
    tick(2);
    singleDisplay = 1'b1;
    expectAt(1, S_SRA, 1, "R8");
    tick(2);
    dispPending = 1'b1;
    expectAt(1, S_SRA, 0, "R8");
    expectAt(1, S_SEX, 1, "R11");
    tick(2);
    dispPending = 1'b0;
    gfxIdle = 1'b0;
    expectAt(1, S_SRA, 0, "R8");
    tick(2);
    gfxIdle = 1'b1;
    expectAt(1, S_SRA, 1, "R8");
    tick(2);
    cpuState = 3'd0;
    expectAt(1, S_SRA, 0, "R7");
    tick(2);

    // R10 S3 holds self-refresh, S4 powers off
    gfxExternal = 1'b1;
    memReqPending = 1'b1;
    cpuState = 3'd5;
    expectAt(1, S_SRA, 1, "R10");
    tick(2);
    cpuState = 3'd6;
    rankAccess = 4'b0001;
    expectAt(1, S_OFF, 1, "R10");
    expectAt(1, S_SRA, 0, "R10");
    expectAt(3, S_CKE, 0, "R10");
    expectAt(3, S_GNT, 0, "R10");
    tick(4);
    cpuState = 3'd0;
    rankAccess = '0;
    expectAt(1, S_OFF, 0, "R10");
    tick(3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

endmodule